// File: doc/BRIEF.md
# Three-wire addressed configuration register loader

This block receives configuration words over a three-wire serial port made of an active-low enable, a serial clock and a serial data line. All three lines are synchronized into the system clock. While the enable is low, each rising edge of the serial clock shifts the data line into a word register, most significant bit first. When the enable returns high, the completed 16-bit word is committed to one of four 14-bit configuration registers. The leading 14 bits of the word are the payload. The trailing 2 bits select the destination register.

All four registers are presented side by side on one parallel output bus. A 12-bit channel code is taken from register 2 and brought out on its own output. The code is the channel number: the radio's centre frequency is that number times 1.024 MHz.

A bit counter clears when the enable falls and stops at 16. If the enable rises before 16 bits have arrived, the word is discarded and an error flag is raised. The next complete commit clears the flag. If more than 16 bits arrive, the most recent 16 are used. The registers do not depend on any radio power state, so they can be written at any time. There is no data stream here, so the pins are plain control and status lines with no valid/ready handshake and no back-pressure.

Top module: `cfg3w_loader`

## Requirements
- R1: After the asynchronous active-low reset, all four registers, the channel code and the error flag read zero.
- R2: A committed word sets register number word[1:0] to word[15:2], where word[15] is the first bit received. The other three registers keep their values. Register k occupies cfg_q bits [14k+13:14k].
- R3: Serial clock edges and data levels that occur while the enable is high have no effect on the registers, on the error flag or on the count of received bits.
- R4: A register changes only at a rising edge of the enable. After 16 bits have been shifted, the registers stay unchanged for as long as the enable stays low.
- R5: A rising edge of the enable with fewer than 16 bits received since the last falling edge writes nothing and sets load_err to 1.
- R6: When more than 16 bits arrive in one enable-low window, the last 16 bits received form the committed word, and no error is raised.
- R7: chan_code always equals bits [11:0] of register 2.
- R8: A complete commit clears load_err to 0. An enable pulse with no serial clock edges counts as a short word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_n | input | 1 | Serial enable, active low; its rising edge commits the word |
| cfg_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| cfg_dat | input | 1 | Serial data, most significant bit first |
| cfg_q | output | 56 | Contents of the four 14-bit registers, register 0 in the low bits |
| chan_code | output | 12 | Channel number taken from register 2 |
| load_err | output | 1 | High after a short-word commit, cleared by a complete commit |

## Verification
The bench builds the block with its default parameters: a 14-bit payload, a 2-bit address and two synchronizer stages. With these values the space is small enough to sweep. Every address is written with a computed set of payloads that includes walking ones, all-ones and arithmetic patterns. Every short word length from 0 to 15 bits is sent, and over-long words of 17 to 20 bits are sent as well. After each transfer, all four registers and the channel code are compared with an arithmetic model held in the bench.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
  localparam int DATA_W   = 14;
  localparam int ADDR_W   = 2;
  localparam int CHAN_REG = 2;
  localparam int CHAN_W   = 12;
endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], d_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl_o  = chain[STAGES-1];
  assign rise_o = lvl_o & ~prev;
  assign fall_o = ~lvl_o & prev;
endmodule

// File: rtl/cfg3w_shifter.sv
module cfg3w_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_lvl_i,
  input  logic              en_fall_i,
  input  logic              sclk_rise_i,
  input  logic              sdat_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      cnt    <= '0;
    end else if (en_fall_i) begin
      cnt <= '0;
    end else if (!en_lvl_i && sclk_rise_i) begin
      word_o <= {word_o[WORD_W-2:0], sdat_i};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  assign full_o = (cnt == CNT_MAX);

  // R6
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_lvl_i |=> ($stable(word_o) && $stable(cnt)));
endmodule

// File: rtl/cfg3w_regfile.sv
module cfg3w_regfile #(
  parameter int DATA_W = 14,
  parameter int ADDR_W = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            commit_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               data_i,
  output logic [(1<<ADDR_W)*DATA_W-1:0]   q_o
);
  localparam int NREG = 1 << ADDR_W;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(k);
    logic [DATA_W-1:0] r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        r <= '0;
      else if (commit_i && addr_i == IDX) r <= data_i;
    end

    assign q_o[k*DATA_W +: DATA_W] = r;

    // R2
    reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && addr_i == IDX) |=> (r == $past(data_i)));
  end

  // R4
  no_write_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(q_o));
endmodule

// File: rtl/cfg3w_loader.sv
module cfg3w_loader
  import cfg3w_pkg::*;
#(
  parameter int D_W    = DATA_W,
  parameter int A_W    = ADDR_W,
  parameter int C_REG  = CHAN_REG,
  parameter int C_W    = CHAN_W,
  parameter int SYNC_N = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_en_n,
  input  logic                        cfg_clk,
  input  logic                        cfg_dat,
  output logic [(1<<A_W)*D_W-1:0]     cfg_q,
  output logic [C_W-1:0]              chan_code,
  output logic                        load_err
);
  localparam int WORD_W = D_W + A_W;

  logic en_lvl, en_rise, en_fall;
  logic sck_lvl, sck_rise, sck_fall;
  logic dat_lvl, dat_rise, dat_fall;
  logic [WORD_W-1:0] word;
  logic full, commit;

  cfg3w_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_en_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cfg_en_n),
    .lvl_o(en_lvl), .rise_o(en_rise), .fall_o(en_fall));

  cfg3w_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cfg_clk),
    .lvl_o(sck_lvl), .rise_o(sck_rise), .fall_o(sck_fall));

  cfg3w_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cfg_dat),
    .lvl_o(dat_lvl), .rise_o(dat_rise), .fall_o(dat_fall));

  cfg3w_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .en_lvl_i(en_lvl), .en_fall_i(en_fall),
    .sclk_rise_i(sck_rise), .sdat_i(dat_lvl),
    .word_o(word), .full_o(full));

  assign commit = en_rise & full;

  cfg3w_regfile #(.DATA_W(D_W), .ADDR_W(A_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit_i(commit),
    .addr_i(word[A_W-1:0]),
    .data_i(word[WORD_W-1:A_W]),
    .q_o(cfg_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_err <= 1'b0;
    else if (en_rise) load_err <= ~full;
  end

  assign chan_code = cfg_q[C_REG*D_W +: C_W];

  // R5
  short_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && !full) |=> (load_err && $stable(cfg_q)));

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && full) |=> !load_err);
endmodule

// File: tb/test_cfg3w_loader.sv
module test_cfg3w_loader;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 14;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en_n = 1'b1, cfg_clk = 1'b0, cfg_dat = 1'b0;
  logic [NR*DW-1:0] cfg_q;
  logic [11:0] chan_code;
  logic load_err;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] mreg [NR];
  logic merr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg3w_loader i_cfg3w_loader (
    .clk(clk), .rst_n(rst_n), .cfg_en_n(cfg_en_n), .cfg_clk(cfg_clk),
    .cfg_dat(cfg_dat), .cfg_q(cfg_q), .chan_code(chan_code), .load_err(load_err));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(string req);
    logic [NR*DW-1:0] e;
    for (int k = 0; k < NR; k++) e[k*DW +: DW] = mreg[k];
    check(req, 64'(cfg_q), 64'(e));
    check({req, "/R7 chan"}, 64'(chan_code), 64'(mreg[2][11:0]));
    check({req, " err"}, 64'(load_err), 64'(merr));
  endtask

  task automatic shift_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      cfg_dat = v[i];
      cyc(4);
      cfg_clk = 1'b1;
      cyc(4);
      cfg_clk = 1'b0;
      cyc(2);
    end
  endtask

  task automatic send(logic [31:0] v, int n);
    cfg_en_n = 1'b0;
    cyc(5);
    shift_bits(v, n);
    cfg_en_n = 1'b1;
    cyc(6);
    if (n >= 16) begin
      mreg[v[1:0]] = v[15:2];
      merr = 1'b0;
    end else begin
      merr = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NR; k++) mreg[k] = '0;
    merr = 1'b0;
    cyc(3);
    check_all("R1 reset");
    rst_n = 1'b1;
    cyc(6);
    check_all("R1 after release");

    // R2 sweep over every address with computed payloads
    for (int a = 0; a < NR; a++) begin
      for (int p = 0; p < 18; p++) begin
        logic [DW-1:0] d;
        if (p < DW)       d = DW'(1) << p;
        else if (p == DW) d = '1;
        else              d = DW'((p * 32'h1A5B + a * 32'h3C7) & 32'h3FFF);
        send({16'h0, d, 2'(a)}, 16);
        check_all("R2 write");
      end
    end

    // R4: no change while enable still low after 16 bits
    cfg_en_n = 1'b0;
    cyc(5);
    shift_bits({16'h0, 14'h2AAA, 2'd1}, 16);
    cyc(20);
    check_all("R4 held before commit");
    cfg_en_n = 1'b1;
    cyc(6);
    mreg[1] = 14'h2AAA;
    merr = 1'b0;
    check_all("R4 commit on rise");

    // R5 / R8: every short length, including zero bits
    for (int n = 0; n < 16; n++) begin
      send(32'h0000_FFFD ^ 32'(n), n);
      check_all(n == 0 ? "R8 zero-bit short" : "R5 short word");
      send({16'h0, 14'(n * 32'h155), 2'd3}, 16);
      check_all("R8 clear err");
    end

    // R3: serial clock toggling while enable high is ignored
    for (int i = 0; i < 20; i++) begin
      cfg_dat = i[0];
      cyc(3);
      cfg_clk = 1'b1;
      cyc(3);
      cfg_clk = 1'b0;
      cyc(2);
    end
    check_all("R3 idle clocks");
    send({16'h0, 14'h1234, 2'd0}, 8);
    check_all("R3 idle clocks not counted");
    send({16'h0, 14'h0F0F, 2'd2}, 16);
    check_all("R3 recover");

    // R6: over-long words, last 16 bits used
    for (int n = 17; n <= 20; n++) begin
      logic [31:0] v;
      v = 32'hB7E1_5163 ^ (32'(n) << 9);
      send(v, n);
      check_all("R6 long word");
    end

    // R7 dedicated channel values
    send({16'h0, 14'h3ABC, 2'd2}, 16);
    check("R7 chan", 64'(chan_code), 64'h ABC);
    send({16'h0, 14'h0001, 2'd2}, 16);
    check("R7 chan", 64'(chan_code), 64'h001);

    // R1 reset clears after activity
    rst_n = 1'b0;
    cyc(2);
    for (int k = 0; k < NR; k++) mreg[k] = '0;
    merr = 1'b0;
    check_all("R1 re-reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule